// File: doc/BRIEF.md
# Dual-Mode Serial Transmitter

This block turns parallel bytes into a serial bit stream in one of two formats. An 8-bit mode register is written through a simple write port and can be read back at any time. Its top bit picks the line format. In asynchronous format each character is framed by a low start bit and a high stop bit. The character carries seven or eight data bits sent least significant bit first, and may carry an even or odd parity bit. In clocked synchronous format exactly eight data bits go out with a companion shift clock and no framing at all. In that format the character-length and parity fields of the register are ignored.

Bytes enter through a valid/ready handshake. An external baud tick paces the line. In asynchronous format every tick advances the line by one bit. In synchronous format ticks alternate between a falling shift-clock edge, where the data changes, and a rising edge, where the receiver samples it. The register contents are captured when a byte is accepted, so a rewrite never disturbs the character already on the line.

Top module: `dual_mode_serial_tx`

## Requirements
- R1: The mode register resets to 0x00. It reads back on regRdData the last value written, from the cycle after the write. Its bits are: bit 7 format select, bit 6 short character, bit 5 parity enable, bit 4 odd parity. Bits 3..0 are stored but have no effect on the line.
- R2: txReady is high when no character is in progress. A byte is taken on a rising clock edge where txValid and txReady are both 1. txReady is then low from the next cycle until the clock edge at which the frame's final tick is sampled.
- R3: With no character in progress, serOut and serClk are both 1. A baud tick at that time leaves them at 1. The outputs change only on clock edges where baudTick is sampled 1.
- R4: With bit 7 = 0, the Nth tick after acceptance drives frame bit N-1 onto serOut. The frame is a start bit 0, then the data bits LSB first, then the optional parity bit, then one stop bit 1. The tick after the stop bit ends the frame.
- R5: With bit 7 = 0, bit 6 = 1 sends 7 data bits and drops bit 7 of the byte. Bit 6 = 0 sends all 8 data bits.
- R6: With bit 7 = 0 and bit 5 = 1, a parity bit follows the data. It is computed over the data bits actually sent. Bit 4 = 0 gives even parity: data plus parity hold an even number of ones. Bit 4 = 1 gives odd parity.
- R7: With bit 5 = 0 no parity bit is sent, and bit 4 has no effect on the line.
- R8: With bit 7 = 1, exactly 8 data bits are sent LSB first, whatever bits 6..4 hold. Odd ticks 1,3,..,15 drop serClk to 0 and present the next bit. Even ticks 2..16 raise serClk with the data unchanged. Tick 17 ends the frame and returns serOut to 1.
- R9: In asynchronous format serClk stays at 1 for the whole frame.
- R10: A register write made while a frame is in progress does not change that frame. A write in the same cycle as acceptance does not change it either. The next frame uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Mode register write strobe |
| regWrData | input | 8 | Mode register write value |
| regRdData | output | 8 | Mode register contents |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | Byte offered |
| txReady | output | 1 | Transmitter can accept a byte |
| baudTick | input | 1 | One-cycle pacing pulse |
| serOut | output | 1 | Serial data line |
| serClk | output | 1 | Shift clock, synchronous format only |

## Verification
The hardest situation to reach is a mode-register rewrite that lands while a frame is on the line, or in the very cycle the byte is accepted. The new value differs in format, length or parity, so a design that reads the live register would visibly bend the frame. Directed frames write a different mode word at a chosen tick index, or together with txValid. They then check that the current frame follows the old word and the next follows the new one. Random frames mix every mode word with random data and random gaps between ticks, so stability between ticks is also exercised.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // mode register layout; bit positions are what software writes
  typedef struct packed {
    logic       syncMode;   // 7
    logic       shortChar;  // 6
    logic       parEn;      // 5
    logic       parOdd;     // 4
    logic       stopLong;   // 3, held only
    logic       multiProc;  // 2, held only
    logic [1:0] clkSel;     // 1:0, held only
  } modeReg_t;

  typedef enum logic {TX_IDLE, TX_ACTIVE} txState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic shiftOut;
    logic clkFall;
    logic clkRise;
    logic finish;
  } txStrobe_t;

endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txValid,
  input  logic      baudTick,
  input  logic      syncMode,
  input  logic      shortChar,
  input  logic      parEn,
  output logic      txReady,
  output txStrobe_t strobe
);

  localparam int CNT_W = $clog2(2 * DATA_W + 2);
  localparam logic [CNT_W-1:0] SYNC_END   = CNT_W'(2 * DATA_W + 1);
  localparam logic [CNT_W-1:0] ASYNC_BASE = CNT_W'(DATA_W + 3);

  txState_t         stateQ;
  logic [CNT_W-1:0] tickCntQ;
  logic [CNT_W-1:0] endTickQ;
  logic [CNT_W-1:0] endTickD;
  logic [CNT_W-1:0] nextCnt;
  logic             syncQ;
  logic             accept;

  assign txReady = (stateQ == TX_IDLE);
  assign accept  = txReady && txValid;
  assign nextCnt = tickCntQ + CNT_W'(1);

  // final tick index: async = start + data + parity + stop + 1
  always_comb begin
    if (syncMode) endTickD = SYNC_END;
    else          endTickD = ASYNC_BASE - CNT_W'(shortChar) + CNT_W'(parEn);
  end

  always_comb begin
    strobe      = '0;
    strobe.load = accept;
    if (stateQ == TX_ACTIVE && baudTick) begin
      if (nextCnt == endTickQ) begin
        strobe.finish = 1'b1;
      end else if (!syncQ) begin
        strobe.shiftOut = 1'b1;
      end else if (nextCnt[0]) begin
        strobe.shiftOut = 1'b1;
        strobe.clkFall  = 1'b1;
      end else begin
        strobe.clkRise = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= TX_IDLE;
      tickCntQ <= '0;
      endTickQ <= '0;
      syncQ    <= 1'b0;
    end else begin
      if (accept) begin
        stateQ   <= TX_ACTIVE;
        tickCntQ <= '0;
        endTickQ <= endTickD;
        syncQ    <= syncMode;
      end else if (stateQ == TX_ACTIVE && baudTick) begin
        tickCntQ <= nextCnt;
        if (strobe.finish) stateQ <= TX_IDLE;
      end
    end
  end

endmodule

// File: rtl/sertx_datapath.sv
module sertx_datapath
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  input  logic [DATA_W-1:0] txData,
  input  txStrobe_t         strobe,
  output modeReg_t          cfg,
  output logic              serOut,
  output logic              serClk
);

  localparam int FRAME_W = DATA_W + 3;

  modeReg_t           modeQ;
  logic [FRAME_W-1:0] shiftQ;
  logic [FRAME_W-1:0] frameVec;
  logic [DATA_W-1:0]  sentData;
  logic               effShort;
  logic               effPar;
  logic               parBit;
  int                 parPos;
  logic               serOutQ;
  logic               serClkQ;

  assign cfg    = modeQ;
  assign serOut = serOutQ;
  assign serClk = serClkQ;

  always_ff @(posedge clk) begin
    if (!rstN)        modeQ <= '0;
    else if (regWrEn) modeQ <= modeReg_t'(regWrData);
  end

  // frame assembly from the live register at the accept edge
  always_comb begin
    effShort = !modeQ.syncMode && modeQ.shortChar;
    effPar   = !modeQ.syncMode && modeQ.parEn;
    sentData = txData;
    if (effShort) sentData[DATA_W-1] = 1'b0;
    parBit   = (^sentData) ^ modeQ.parOdd;
    parPos   = effShort ? DATA_W : DATA_W + 1;
    frameVec = '1;
    if (modeQ.syncMode) begin
      frameVec[DATA_W-1:0] = txData;
    end else begin
      frameVec[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
        if (!(effShort && i == DATA_W - 1)) frameVec[i+1] = txData[i];
      end
      for (int j = 1; j < FRAME_W; j++) begin
        if (effPar && j == parPos) frameVec[j] = parBit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ  <= '1;
      serOutQ <= 1'b1;
      serClkQ <= 1'b1;
    end else begin
      if (strobe.load) begin
        shiftQ <= frameVec;
      end else if (strobe.shiftOut) begin
        shiftQ  <= {1'b1, shiftQ[FRAME_W-1:1]};
        serOutQ <= shiftQ[0];
      end
      if (strobe.clkFall) serClkQ <= 1'b0;
      if (strobe.clkRise) serClkQ <= 1'b1;
      if (strobe.finish) begin
        serOutQ <= 1'b1;
        serClkQ <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dual_mode_serial_tx.sv
module dual_mode_serial_tx
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  input  logic              baudTick,
  output logic              serOut,
  output logic              serClk
);

  txStrobe_t strobe;
  modeReg_t  cfg;

  assign regRdData = cfg;

  sertx_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .txValid   (txValid),
    .baudTick  (baudTick),
    .syncMode  (cfg.syncMode),
    .shortChar (cfg.shortChar),
    .parEn     (cfg.parEn),
    .txReady   (txReady),
    .strobe    (strobe)
  );

  sertx_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .txData    (txData),
    .strobe    (strobe),
    .cfg       (cfg),
    .serOut    (serOut),
    .serClk    (serClk)
  );

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
  input logic clk,
  input logic rstN,
  input logic txValid,
  input logic txReady,
  input logic baudTick,
  input logic serOut,
  input logic serClk
);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> (serOut && serClk)); // R3

  AST_QUIET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !baudTick |=> ($stable(serOut) && $stable(serClk))); // R3

  AST_READY_DROPS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && txValid) |=> !txReady); // R2

  AST_READY_WAITS_FOR_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!txReady && !baudTick) |=> !txReady); // R2

  AST_DATA_STABLE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serClk) |-> $stable(serOut)); // R8

  AST_CLK_LOW_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !serClk |-> !txReady); // R8

endmodule

bind dual_mode_serial_tx sertx_checker i_sertx_checker (
  .clk      (clk),
  .rstN     (rstN),
  .txValid  (txValid),
  .txReady  (txReady),
  .baudTick (baudTick),
  .serOut   (serOut),
  .serClk   (serClk)
);

// File: tb/test_dual_mode_serial_tx.sv
module test_dual_mode_serial_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [7:0] txData = '0;
  logic       txValid = 1'b0;
  logic       txReady;
  logic       baudTick = 1'b0;
  logic       serOut;
  logic       serClk;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  dual_mode_serial_tx i_dual_mode_serial_tx (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .txData(txData), .txValid(txValid),
    .txReady(txReady), .baudTick(baudTick), .serOut(serOut), .serClk(serClk)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // async frame: number of line bits (start + data + parity + stop)
  function automatic int asyncBits(input logic [7:0] m);
    return 2 + (m[6] ? 7 : 8) + (m[5] ? 1 : 0);
  endfunction

  // async frame bit at position i (0 = start)
  function automatic logic asyncBit(input logic [7:0] m, input logic [7:0] d, input int i);
    int dl;
    logic [7:0] sent;
    dl = m[6] ? 7 : 8;
    sent = m[6] ? {1'b0, d[6:0]} : d;
    if (i == 0) return 1'b0;
    if (i <= dl) return d[i-1];
    if (i == dl + 1 && m[5]) return (^sent) ^ m[4];
    return 1'b1;
  endfunction

  task automatic writeReg(input logic [7:0] m);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = m;
    @(negedge clk);
    regWrEn = 1'b0;
    check(regRdData == m, "R1 readback", regRdData, m);
  endtask

  task automatic tickOnce();
    @(negedge clk);
    baudTick = 1'b1;
    @(negedge clk);
    baudTick = 1'b0;
  endtask

  // doWrite: program m first; wrAt = -1 none, 0 with accept, k before tick k
  task automatic sendFrame(input logic [7:0] m, input logic [7:0] d, input bit doWrite,
                           input int wrAt, input logic [7:0] m2, input string extra);
    int endT, n;
    logic [2:0] exp3, act3;
    string tag;
    if (doWrite) writeReg(m);
    @(negedge clk);
    txData = d;
    txValid = 1'b1;
    if (wrAt == 0) begin
      regWrEn = 1'b1;
      regWrData = m2;
    end
    @(negedge clk);
    txValid = 1'b0;
    regWrEn = 1'b0;
    check(txReady == 1'b0, {"R2 busy after accept", extra}, txReady, 0);
    n = asyncBits(m);
    endT = m[7] ? 17 : n + 1;
    exp3 = 3'b110;
    for (int k = 1; k <= endT; k++) begin
      int gap;
      if (k == wrAt) writeReg(m2);
      gap = int'($urandom_range(0, 3));
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        act3 = {serOut, serClk, txReady};
        check(act3 == exp3, {"R3 quiet between ticks", extra}, act3, exp3);
      end
      tickOnce();
      if (k == endT) begin
        exp3 = 3'b111;
        tag = "R2 frame end";
      end else if (m[7]) begin
        exp3 = (k % 2 == 1) ? {d[(k-1)/2], 2'b00} : {d[k/2-1], 2'b10};
        tag = "R8 sync";
      end else begin
        exp3 = {asyncBit(m, d, k - 1), 2'b10};
        if (m[5] && k - 1 == n - 2) tag = m[4] ? "R6 odd parity" : "R6 even parity";
        else if (!m[5] && k - 1 == n - 1) tag = "R7 no parity, stop";
        else if (m[6] && k - 1 == 8) tag = "R5 short char";
        else tag = "R4_R9 async";
      end
      act3 = {serOut, serClk, txReady};
      check(act3 == exp3, {tag, extra}, act3, exp3);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] m, d;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(regRdData == 8'h00, "R1 reset value", regRdData, 0);
    check({serOut, serClk, txReady} == 3'b111, "R3 reset idle", {serOut, serClk, txReady}, 7);

    // idle tick leaves the line alone
    tickOnce();
    check({serOut, serClk, txReady} == 3'b111, "R3 idle tick", {serOut, serClk, txReady}, 7);

    // directed corners
    sendFrame(8'h00, 8'hA5, 1'b1, -1, 8'h00, " 8N1");
    sendFrame(8'h40, 8'h80, 1'b1, -1, 8'h00, " 7-bit drops MSB");
    sendFrame(8'h20, 8'h00, 1'b1, -1, 8'h00, " even on zero");
    sendFrame(8'h30, 8'h00, 1'b1, -1, 8'h00, " odd on zero");
    sendFrame(8'h70, 8'hFF, 1'b1, -1, 8'h00, " 7-bit odd");
    sendFrame(8'h10, 8'h3C, 1'b1, -1, 8'h00, " sense without enable");
    sendFrame(8'hF0, 8'h96, 1'b1, -1, 8'h00, " sync ignores 6..4");
    sendFrame(8'h80, 8'h01, 1'b1, -1, 8'h00, " sync");

    // R10: rewrite mid-frame, then the next frame follows the new word
    sendFrame(8'h00, 8'h5A, 1'b1, 4, 8'h80, " R10 mid-frame write");
    check(regRdData == 8'h80, "R10 new word stored", regRdData, 8'h80);
    sendFrame(8'h80, 8'h5A, 1'b0, -1, 8'h00, " R10 next frame");
    sendFrame(8'h80, 8'hC3, 1'b1, 9, 8'h60, " R10 sync mid write");
    sendFrame(8'h60, 8'hC3, 1'b0, -1, 8'h00, " R10 next frame");
    // R10: write in the acceptance cycle
    sendFrame(8'h20, 8'h77, 1'b1, 0, 8'hD0, " R10 write at accept");
    sendFrame(8'hD0, 8'h77, 1'b0, -1, 8'h00, " R10 next frame");

    // random mix
    for (int r = 0; r < 60; r++) begin
      m = 8'($urandom);
      d = 8'($urandom);
      sendFrame(m, d, 1'b1, -1, 8'h00, " random");
      if ($urandom_range(0, 3) == 0) begin
        tickOnce();
        check({serOut, serClk, txReady} == 3'b111, "R3 idle tick", {serOut, serClk, txReady}, 7);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule